// File: doc/BRIEF.md
# PHY Interrupt Control and Status Register

This block is the interrupt register of an Ethernet PHY's management register space. PHY event sources deliver single-cycle pulses: link up, link down, remote fault, link partner acknowledge, parallel detect fault, page received, receive error and jabber. Each pulse latches into a status flag. A byte of enable flags in the same 16-bit register chooses which latched events drive the interrupt pin. A separate control register sets whether the pin is active high or active low.

Management software reaches the block through a plain register access port. It presents an address, write data and a write strobe, or an address and a read strobe. A read answers one cycle later with `rd_valid` high. There is no back-pressure: every strobe is accepted in the cycle it is presented. When software reads the interrupt register, the latched status flags are cleared. The usual setup writes 0x0500, which enables link up and link down only. Writing zero masks every event.

Top module: `phy_irq_regs`

## Requirements
- R1: After reset, every enable and every status flag is 0, the polarity is active low, the pin is high, and reads of address 0x1B and of 0x1F both return 0.
- R2: Event pulse bit i sets status bit i whether or not that event is enabled. The bit mapping is 7 jabber, 6 receive error, 5 page received, 4 parallel detect fault, 3 link partner acknowledge, 2 link down, 1 remote fault, 0 link up.
- R3: A write to 0x1B loads wdata[15:8] into the enables, with bit 8+i enabling event i. wdata[7:0] is ignored and the status flags are left as they were.
- R4: A read strobe in cycle t gives rd_valid high in cycle t+1, with rdata holding the read value. A read of 0x1B returns the enables in bits 15:8 and the status flags in bits 7:0. Without a read strobe, rd_valid and rdata are 0.
- R5: A read of 0x1B clears all status flags, so an immediate second read returns a low byte of 0.
- R6: An event pulse in the same cycle as a clearing read is not in the data returned by that read, and it stays latched afterwards.
- R7: The interrupt is active exactly when the bitwise AND of the status flags and the enables is non-zero.
- R8: Bit 9 of a write to 0x1F sets the pin polarity: 1 makes the pin active high, 0 makes it active low. A read of 0x1F returns only that bit, in position 9.
- R9: Writing 0x0500 to 0x1B makes only link up and link down drive the pin. Writing 0 releases the pin while the latched status flags stay readable.
- R10: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| evt_pulse | input | 8 | Single-cycle event pulses, one bit per event |
| irq_pin | output | 1 | Interrupt pin at the programmed polarity |

## Verification
The bench builds the block with its default parameters: a 5-bit address, a 16-bit word, eight events, the interrupt register at 0x1B, the control register at 0x1F and the polarity at bit 9. With these values every individual event bit can be pulsed, and every enable pattern in the upper byte can be written and read back. Both pin polarities are covered, including the case where an event collides with a clearing read. Because the enable byte and the status byte fill the whole word, the bench also shows that writes to the status half are dropped.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

  // Event positions inside the status byte (the enables sit at +N_EVT)
  typedef enum int unsigned {
    EV_LINK_UP    = 0,
    EV_RMT_FAULT  = 1,
    EV_LINK_DOWN  = 2,
    EV_LP_ACK     = 3,
    EV_PAR_FAULT  = 4,
    EV_PAGE_RX    = 5,
    EV_RX_ERR     = 6,
    EV_JABBER     = 7
  } evt_idx_e;

  // Which register an access hits, and how
  typedef struct packed {
    logic irq_wr;
    logic irq_rd;
    logic ctl_wr;
    logic ctl_rd;
  } acc_hit_t;

endpackage

// File: rtl/phy_irq_decode.sv
module phy_irq_decode
  import phy_irq_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 5,
  parameter logic [ADDR_W-1:0]    IRQ_ADDR = 5'h1B,
  parameter logic [ADDR_W-1:0]    CTL_ADDR = 5'h1F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output acc_hit_t          hit
);

  logic sel_irq;
  logic sel_ctl;

  assign sel_irq = (addr == IRQ_ADDR);
  assign sel_ctl = (addr == CTL_ADDR);

  always_comb begin
    hit.irq_wr = wr_en & sel_irq;
    hit.irq_rd = rd_en & sel_irq;
    hit.ctl_wr = wr_en & sel_ctl;
    hit.ctl_rd = rd_en & sel_ctl;
  end

endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status #(
  parameter int unsigned N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_EVT-1:0] evt_pulse,
  output logic [N_EVT-1:0] st_q
);

  // One sticky flag per event; a new pulse wins over a clearing read
  for (genvar i = 0; i < N_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
      end else begin
        st_q[i] <= (st_q[i] & ~clr) | evt_pulse[i];
      end
    end
  end

endmodule

// File: rtl/phy_irq_cfg.sv
module phy_irq_cfg #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_EVT   = 8,
  parameter int unsigned POL_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              pol_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_EVT-1:0]  en_q,
  output logic              pol_q
);

  localparam int unsigned EN_LSB = DATA_W - N_EVT;

  logic unused_wdata;
  assign unused_wdata = ^wdata[EN_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= 1'b0;
    end else begin
      if (en_wr)  en_q  <= wdata[DATA_W-1:EN_LSB];
      if (pol_wr) pol_q <= wdata[POL_BIT];
    end
  end

endmodule

// File: rtl/phy_irq_pin.sv
module phy_irq_pin #(
  parameter int unsigned N_EVT = 8
) (
  input  logic [N_EVT-1:0] st_q,
  input  logic [N_EVT-1:0] en_q,
  input  logic             pol_q,
  output logic             irq_pin
);

  logic active;

  assign active  = |(st_q & en_q);
  assign irq_pin = pol_q ? active : ~active;

endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 5,
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       N_EVT    = 8,
  parameter logic [ADDR_W-1:0] IRQ_ADDR = 5'h1B,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 5'h1F,
  parameter int unsigned       POL_BIT  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic [N_EVT-1:0]  evt_pulse,
  output logic              irq_pin
);

  localparam int unsigned EN_LSB = DATA_W - N_EVT;

  acc_hit_t          hit;
  logic [N_EVT-1:0]  st_q;
  logic [N_EVT-1:0]  en_q;
  logic              pol_q;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_valid_q;

  phy_irq_decode #(
    .ADDR_W   (ADDR_W),
    .IRQ_ADDR (IRQ_ADDR),
    .CTL_ADDR (CTL_ADDR)
  ) u_decode (
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .hit   (hit)
  );

  phy_irq_status #(.N_EVT(N_EVT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hit.irq_rd),
    .evt_pulse (evt_pulse),
    .st_q      (st_q)
  );

  phy_irq_cfg #(
    .DATA_W  (DATA_W),
    .N_EVT   (N_EVT),
    .POL_BIT (POL_BIT)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_wr  (hit.irq_wr),
    .pol_wr (hit.ctl_wr),
    .wdata  (wdata),
    .en_q   (en_q),
    .pol_q  (pol_q)
  );

  phy_irq_pin #(.N_EVT(N_EVT)) u_pin (
    .st_q    (st_q),
    .en_q    (en_q),
    .pol_q   (pol_q),
    .irq_pin (irq_pin)
  );

  // Readback mux: pre-clear status, current enables
  always_comb begin
    rd_word = '0;
    if (hit.irq_rd) begin
      rd_word[DATA_W-1:EN_LSB] = en_q;
      rd_word[N_EVT-1:0]       = st_q;
    end else if (hit.ctl_rd) begin
      rd_word[POL_BIT] = pol_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rdata_q    <= rd_en ? rd_word : '0;
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int unsigned       ADDR_W   = 5,
  parameter int unsigned       N_EVT    = 8,
  parameter logic [ADDR_W-1:0] IRQ_ADDR = 5'h1B
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [N_EVT-1:0]  evt_pulse,
  input logic              rd_valid,
  input logic              irq_pin,
  input logic [N_EVT-1:0]  st_q,
  input logic [N_EVT-1:0]  en_q,
  input logic              pol_q
);

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((st_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == IRQ_ADDR) |=> $stable(en_q));

  // R4
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R4
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IRQ_ADDR && evt_pulse == '0) |=> (st_q == '0));

  // R6
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == IRQ_ADDR) |=> (st_q == $past(evt_pulse)));

  // R7
  pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin == pol_q) == ((st_q & en_q) != '0));

endmodule

bind phy_irq_regs phy_irq_chk #(
  .ADDR_W   (ADDR_W),
  .N_EVT    (N_EVT),
  .IRQ_ADDR (IRQ_ADDR)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .evt_pulse (evt_pulse),
  .rd_valid  (rd_valid),
  .irq_pin   (irq_pin),
  .st_q      (st_q),
  .en_q      (en_q),
  .pol_q     (pol_q)
);

// File: tb/phy_irq_regs_tb_top.sv
module phy_irq_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic [7:0]  evt_pulse = '0;
  logic        irq_pin;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int m_en = 0;
  int m_st = 0;
  int m_pol = 0;
  int m_rdata = 0;
  int m_rvalid = 0;

  always #2 clk = ~clk;

  phy_irq_regs dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wdata     (wdata),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .evt_pulse (evt_pulse),
    .irq_pin   (irq_pin)
  );

  function automatic int exp_pin();
    int act;
    act = ((m_st & m_en) != 0) ? 1 : 0;
    return (m_pol != 0) ? act : 1 - act;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (int'(irq_pin) != exp_pin() || int'(rd_valid) != m_rvalid ||
        int'(rdata) != m_rdata) begin
      errors++;
      $display("FAIL %s: pin=%0d valid=%0d rdata=%h expected pin=%0d valid=%0d rdata=%h",
               tag, irq_pin, rd_valid, rdata, exp_pin(), m_rvalid, m_rdata[15:0]);
    end
  endtask

  // Advance one edge, update the model from the held inputs, compare
  task automatic step(input string tag);
    int a;
    @(posedge clk);
    #1;
    a = int'(addr);
    m_rvalid = int'(rd_en);
    m_rdata  = 0;
    if (rd_en) begin
      if (a == 'h1B) m_rdata = (m_en << 8) | m_st;
      else if (a == 'h1F) m_rdata = m_pol << 9;
    end
    if (rd_en && a == 'h1B) m_st = 0;
    m_st = m_st | int'(evt_pulse);
    if (wr_en && a == 'h1B) m_en = int'(wdata[15:8]);
    if (wr_en && a == 'h1F) m_pol = int'(wdata[9]);
    compare(tag);
  endtask

  task automatic op(input logic w, input logic r, input logic [4:0] ad,
                    input logic [15:0] wd, input logic [7:0] ev, input string tag);
    wr_en = w; rd_en = r; addr = ad; wdata = wd; evt_pulse = ev;
    step(tag);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt_pulse = '0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    compare("R1 reset outputs");
    op(0, 1, 5'h1B, 0, 0, "R1 read irq after reset");
    op(0, 1, 5'h1F, 0, 0, "R1 read ctl after reset");
    op(0, 0, 0, 0, 0, "R1 idle");

    // R2: each event alone, no enables, pin must stay idle
    for (int i = 0; i < 8; i++) begin
      op(0, 0, 0, 0, 8'(1 << i), "R2 single event latch");
      op(0, 1, 5'h1B, 0, 0, "R2 readback of one event");
    end
    op(0, 0, 0, 0, 8'hFF, "R2 all events at once");

    // R3: enable write, status byte of wdata ignored
    op(1, 0, 5'h1B, 16'hA5FF, 0, "R3 enable write");
    op(0, 1, 5'h1B, 0, 0, "R3 R4 readback enables and status");
    op(0, 1, 5'h1B, 0, 0, "R5 second read sees cleared status");
    op(1, 0, 5'h1B, 16'h00FF, 0, "R3 status write ignored");
    op(0, 1, 5'h1B, 0, 0, "R3 status remains clear");

    // R9 / R7: link events only
    op(1, 0, 5'h1B, 16'h0500, 0, "R9 enable link up and down");
    op(0, 0, 0, 0, 8'h01, "R9 R7 link up drives pin");
    op(0, 0, 0, 0, 0, "R7 pin held while latched");
    op(0, 1, 5'h1B, 0, 0, "R5 read releases pin");
    op(0, 0, 0, 0, 8'h80, "R9 jabber masked");
    op(0, 0, 0, 0, 8'h02, "R9 remote fault masked");

    // R8: polarity
    op(1, 0, 5'h1F, 16'hFFFF, 0, "R8 active high");
    op(0, 1, 5'h1F, 0, 0, "R8 ctl readback bit 9 only");
    op(0, 0, 0, 0, 8'h04, "R8 R7 link down active high");
    op(1, 0, 5'h1F, 16'hFDFF, 0, "R8 back to active low");

    // R6: event collides with clearing read
    op(0, 1, 5'h1B, 0, 8'h01, "R6 collide read");
    op(0, 0, 0, 0, 0, "R6 pin still asserted");
    op(0, 1, 5'h1B, 0, 0, "R6 event kept after collision");

    // R9: disable all while status stays readable
    op(0, 0, 0, 0, 8'h05, "R9 link events latched");
    op(1, 0, 5'h1B, 16'h0000, 0, "R9 disable all releases pin");
    op(0, 1, 5'h1B, 0, 0, "R9 status still readable");

    // Write and read in the same cycle: old enables returned
    op(1, 1, 5'h1B, 16'hFF00, 8'h10, "R4 read with write returns old enables");
    op(0, 1, 5'h1B, 0, 0, "R4 new enables visible");

    // R10: other addresses
    op(1, 0, 5'h10, 16'hFFFF, 0, "R10 foreign write");
    op(1, 0, 5'h1A, 16'hFFFF, 0, "R10 neighbour write");
    op(0, 1, 5'h10, 0, 0, "R10 foreign read zero");
    op(0, 1, 5'h1B, 0, 0, "R10 irq register unchanged");
    op(0, 1, 5'h1F, 0, 0, "R10 ctl register unchanged");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule